// File: doc/BRIEF.md
# Shared Data-Line-3 / Hardware-Reset Pin Controller

This block decides, on every clock, which role one shared pad plays. The pad can carry the fourth bit of a quad-wide transfer, or it can act as an active-low hardware reset input. The controller also watches the pad while it is in the reset role. When the pad is held low for long enough, the block issues a single reset request to the device's reset sequencer.

Role selection uses two configuration bits and the chip-select level. The first bit enables the reset function and the second bit enables quad mode. When the reset function is enabled and quad mode is on, the pad is reset-capable only while chip select is deasserted. After a quad transfer that returned data to the host, the controller drives the pad high for a set number of cycles once chip select rises. This stops a slow external pull-up from letting the pad drift low and look like a reset pulse.

All pin-level inputs pass through a synchronizer of `SYNC_STAGES` flops before any decision is made. The pulse length `TRP_CYC` and the drive-high window `TCS_CYC` are given in clock cycles.

Top module: `io3_reset_pin_ctrl`

## Requirements
- R1: While the reset-enable input is 0, `rst_req` never asserts, whatever the pad, chip-select and quad-mode levels are.
- R2: With reset enabled and quad mode off, a low pad counts toward a reset whether chip select is high or low.
- R3: With quad mode on, `data_sel` is 1 exactly while chip select is low. A low pad counts toward a reset only while chip select is high.
- R4: A reset request is issued only after the pad has been low in the reset role for `TRP_CYC` consecutive synchronized cycles. Any shorter low interval, or a loss of the reset role, restarts the count and requests nothing. A low interval of exactly `TRP_CYC` cycles is enough.
- R5: Every input is seen through `SYNC_STAGES` flops and every output is registered. An input change therefore appears on `data_sel` `SYNC_STAGES`+1 rising edges after it is sampled.
- R6: `rst_req` is a one-cycle pulse. After a pulse, no further request is issued until the pad has been seen high again, however long the low lasts and however often the count restarts.
- R7: If chip select was low, quad mode on and `host_read` high in at least one synchronized cycle of a transfer, then `drive_hi` is 1 for `TCS_CYC` cycles starting with the cycle in which the chip-select rise takes effect. The window ends early if chip select falls again. A transfer without a read produces no drive.
- R8: While `rst` is high, and on the first cycle after it, `rst_req`, `data_sel` and `drive_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock that times the pulse |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| pin_in | input | 1 | Level seen on the shared pad |
| quad_en | input | 1 | Quad-mode configuration bit |
| rst_en | input | 1 | Reset-function enable bit |
| host_read | input | 1 | High while the current transfer returns data to the host |
| rst_req | output | 1 | One-cycle hardware reset request |
| data_sel | output | 1 | Pad is in the data-line role |
| drive_hi | output | 1 | Drive the pad high after a read transfer |

## Verification
The checker examines every cycle for properties that need only the current and previous cycle:
- a request is always a single cycle;
- a request never appears while the block is disabled, while the pad is high, or while the pad is in the data role;
- the drive-high enable and the data-role select are never both active.

Other behaviour depends on history that spans many cycles, and only the bench's scenarios can show it. This covers the exact pulse length at which a reset is accepted, the restart of the count after a glitch, re-arming after the pad returns high, and the length of the drive window and its early end. A behavioural model also compares all three outputs with the design on every clock.

// File: rtl/io3_pin_pkg.sv
package io3_pin_pkg;

  // One synchronized snapshot of the pad-side inputs.
  typedef struct packed {
    logic cs_n;
    logic pin;
    logic quad;
    logic en;
    logic rd;
  } pin_sample_t;

  localparam int SAMPLE_W = $bits(pin_sample_t);

  // Idle levels: deselected, pad pulled high, features off.
  localparam pin_sample_t SAMPLE_IDLE = '{cs_n: 1'b1, pin: 1'b1, quad: 1'b0, en: 1'b0, rd: 1'b0};

  function automatic logic reset_role(input pin_sample_t s);
    return s.en && (!s.quad || s.cs_n);
  endfunction

  function automatic logic data_role(input pin_sample_t s);
    return s.quad && !s.cs_n;
  endfunction

endpackage

// File: rtl/io3_sync_chain.sv
module io3_sync_chain #(
  parameter int                 WIDTH   = 5,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= RST_VAL;
        else     stg[k] <= stg[k-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/io3_pulse_detect.sv
module io3_pulse_detect #(
  parameter int TRP_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic role_rst,
  input  logic pin_s,
  output logic rst_req
);

  localparam int CNT_W = $clog2(TRP_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TRP_CYC - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TRP_CYC);

  logic [CNT_W-1:0] low_cnt;
  logic             armed;
  logic             low_now;
  logic             fire;

  assign low_now = role_rst && !pin_s;
  assign fire    = low_now && armed && (low_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      armed   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= fire;
      if (!low_now)             low_cnt <= '0;
      else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
      if (pin_s)     armed <= 1'b1;
      else if (fire) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/io3_drive_timer.sv
module io3_drive_timer #(
  parameter int TCS_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_s,
  input  logic quad_s,
  input  logic rd_s,
  output logic drive_hi
);

  localparam int TW = $clog2(TCS_CYC + 1);
  localparam logic [TW-1:0] LOAD = TW'(TCS_CYC);

  logic [TW-1:0] left_q, left_d;
  logic          cs_prev;
  logic          rd_seen;
  logic          cs_rise;

  assign cs_rise = cs_n_s && !cs_prev;

  always_comb begin
    if (cs_rise && rd_seen) left_d = LOAD;
    else if (!cs_n_s)       left_d = '0;
    else if (left_q != '0)  left_d = left_q - 1'b1;
    else                    left_d = left_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q   <= '0;
      cs_prev  <= 1'b1;
      rd_seen  <= 1'b0;
      drive_hi <= 1'b0;
    end else begin
      left_q   <= left_d;
      cs_prev  <= cs_n_s;
      drive_hi <= (left_d != '0);
      if (cs_rise)                          rd_seen <= 1'b0;
      else if (!cs_n_s && quad_s && rd_s)   rd_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/io3_reset_pin_ctrl.sv
module io3_reset_pin_ctrl
  import io3_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TRP_CYC     = 8,
  parameter int TCS_CYC     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic pin_in,
  input  logic quad_en,
  input  logic rst_en,
  input  logic host_read,
  output logic rst_req,
  output logic data_sel,
  output logic drive_hi
);

  pin_sample_t smp_raw, smp_s;
  logic        role_rst;

  assign smp_raw = '{cs_n: cs_n, pin: pin_in, quad: quad_en, en: rst_en, rd: host_read};

  io3_sync_chain #(
    .WIDTH   (SAMPLE_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SAMPLE_IDLE)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (smp_raw),
    .q   (smp_s)
  );

  assign role_rst = reset_role(smp_s);

  always_ff @(posedge clk) begin
    if (rst) data_sel <= 1'b0;
    else     data_sel <= data_role(smp_s);
  end

  io3_pulse_detect #(.TRP_CYC(TRP_CYC)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .role_rst (role_rst),
    .pin_s    (smp_s.pin),
    .rst_req  (rst_req)
  );

  io3_drive_timer #(.TCS_CYC(TCS_CYC)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .cs_n_s   (smp_s.cs_n),
    .quad_s   (smp_s.quad),
    .rd_s     (smp_s.rd),
    .drive_hi (drive_hi)
  );

endmodule

// File: rtl/io3_reset_pin_checker.sv
module io3_reset_pin_checker (
  input logic clk,
  input logic rst,
  input logic rst_req,
  input logic data_sel,
  input logic drive_hi,
  input logic en_s,
  input logic pin_s
);

  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst) rst_req |=> !rst_req); // R6
  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst) rst_req |-> $past(en_s)); // R1
  AST_REQ_PIN_WAS_LOW:  assert property (@(posedge clk) disable iff (rst) rst_req |-> $past(!pin_s)); // R4
  AST_REQ_NOT_DATA:     assert property (@(posedge clk) disable iff (rst) rst_req |-> !data_sel); // R3
  AST_DRIVE_NOT_DATA:   assert property (@(posedge clk) disable iff (rst) drive_hi |-> !data_sel); // R7

endmodule

bind io3_reset_pin_ctrl io3_reset_pin_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .rst_req  (rst_req),
  .data_sel (data_sel),
  .drive_hi (drive_hi),
  .en_s     (smp_s.en),
  .pin_s    (smp_s.pin)
);

// File: tb/io3_reset_pin_ctrl_bench.sv
module io3_reset_pin_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int S   = 2;
  localparam int TRP = 8;
  localparam int TCS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, pin_in = 1'b1, quad_en = 1'b0, rst_en = 1'b0, host_read = 1'b0;
  logic rst_req, data_sel, drive_hi;

  int checks = 0, errors = 0;
  int n_req = 0, n_drv = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io3_reset_pin_ctrl #(.SYNC_STAGES(S), .TRP_CYC(TRP), .TCS_CYC(TCS)) u_io3_reset_pin_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .pin_in(pin_in), .quad_en(quad_en),
    .rst_en(rst_en), .host_read(host_read),
    .rst_req(rst_req), .data_sel(data_sel), .drive_hi(drive_hi)
  );

  // Behavioural reference: delay lines as bit queues, integers for history.
  bit q_cs[$], q_pin[$], q_quad[$], q_en[$], q_rd[$];
  int m_low, m_left;
  bit m_armed, m_prev_cs, m_seen;
  bit m_req, m_sel, m_drv;

  task automatic model_reset();
    q_cs = {}; q_pin = {}; q_quad = {}; q_en = {}; q_rd = {};
    for (int i = 0; i < S; i++) begin
      q_cs.push_back(1); q_pin.push_back(1); q_quad.push_back(0); q_en.push_back(0); q_rd.push_back(0);
    end
    m_low = 0; m_left = 0; m_armed = 0; m_prev_cs = 1; m_seen = 0;
    m_req = 0; m_sel = 0; m_drv = 0;
  endtask

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      bit c, p, qd, e, r, lowr, rise;
      c = q_cs[0]; p = q_pin[0]; qd = q_quad[0]; e = q_en[0]; r = q_rd[0];
      lowr  = e && (!qd || c) && !p;
      m_req = lowr && m_armed && (m_low == TRP - 1);
      m_low = lowr ? m_low + 1 : 0;
      if (p) m_armed = 1; else if (m_req) m_armed = 0;
      m_sel = qd && !c;
      rise  = c && !m_prev_cs;
      if (rise && m_seen) m_left = TCS;
      else if (!c) m_left = 0;
      else if (m_left > 0) m_left--;
      m_drv = (m_left != 0);
      if (rise) m_seen = 0; else if (!c && qd && r) m_seen = 1;
      m_prev_cs = c;
      void'(q_cs.pop_front()); void'(q_pin.pop_front()); void'(q_quad.pop_front());
      void'(q_en.pop_front()); void'(q_rd.pop_front());
      q_cs.push_back(cs_n); q_pin.push_back(pin_in); q_quad.push_back(quad_en);
      q_en.push_back(rst_en); q_rd.push_back(host_read);
    end
  end

  // R5: every-clock comparison against the model, sampled at the falling edge.
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if ({rst_req, data_sel, drive_hi} !== {m_req, m_sel, m_drv}) begin
        errors++;
        $display("FAIL R5 model compare t=%0t actual req/sel/drv=%b%b%b expected=%b%b%b",
                 $time, rst_req, data_sel, drive_hi, m_req, m_sel, m_drv);
      end
      if (rst_req === 1'b1) n_req++;
      if (drive_hi === 1'b1) n_drv++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Snapshot counters halfway between falling edges.
  task automatic snap(output int r, output int d);
    @(posedge clk); #1; r = n_req; d = n_drv;
  endtask

  task automatic low_pulse(input int len, output int pulses);
    int r0, d0, r1, d1;
    snap(r0, d0); @(negedge clk);
    pin_in = 0; step(len); pin_in = 1; step(S + 4);
    snap(r1, d1); @(negedge clk);
    pulses = r1 - r0;
  endtask

  initial begin
    int p, r0, d0, r1, d1;
    model_reset();
    step(4);
    check("R8 reset req", rst_req, 0);
    check("R8 reset sel", data_sel, 0);
    check("R8 reset drv", drive_hi, 0);
    rst = 0; step(1);
    check("R8 first cycle sel", data_sel, 0);
    step(S + 2);

    // R1: disabled, long low pad
    low_pulse(30, p); check("R1 disabled no request", p, 0);

    // R2: enabled, quad off, chip select low still counts
    rst_en = 1; cs_n = 0; step(S + 2);
    low_pulse(30, p); check("R2 cs low quad off request", p, 1);
    cs_n = 1; step(2);
    low_pulse(30, p); check("R6 one pulse on long low", p, 1);

    // R4: glitches shorter than the minimum restart the count
    low_pulse(TRP - 1, p); check("R4 short glitch", p, 0);
    snap(r0, d0); @(negedge clk);
    pin_in = 0; step(TRP - 1); pin_in = 1; step(1); pin_in = 0; step(TRP - 1); pin_in = 1; step(S + 4);
    snap(r1, d1); @(negedge clk);
    check("R4 two glitches restart", r1 - r0, 0);
    low_pulse(TRP, p); check("R4 exact minimum accepted", p, 1);

    // R3 / R5: quad on, chip select low -> data role after S+1 edges
    quad_en = 1; cs_n = 0; step(S); #1;
    check("R5 latency not yet", data_sel, 0);
    step(1); #1;
    check("R3 data role cs low", data_sel, 1);
    low_pulse(30, p); check("R3 no reset in data role", p, 0);

    // R3: quad on, chip select high -> reset role
    cs_n = 1; step(S + 2); #1;
    check("R3 data role released", data_sel, 0);
    low_pulse(30, p); check("R3 reset role cs high", p, 1);

    // R6: no re-arm while the pad stays low, even across count restarts
    snap(r0, d0); @(negedge clk);
    pin_in = 0; step(TRP + 4);
    cs_n = 0; step(3); cs_n = 1; step(TRP + 6);
    pin_in = 1; step(S + 4);
    snap(r1, d1); @(negedge clk);
    check("R6 no re-arm while low", r1 - r0, 1);
    low_pulse(TRP + 2, p); check("R6 re-armed after high", p, 1);

    // R7: drive window after a read transfer
    rst_en = 0;
    snap(r0, d0); @(negedge clk);
    cs_n = 0; host_read = 1; step(3); host_read = 0; step(1); cs_n = 1; step(TCS + S + 4);
    snap(r1, d1); @(negedge clk);
    check("R7 full drive window", d1 - d0, TCS);
    snap(r0, d0); @(negedge clk);
    cs_n = 0; step(4); cs_n = 1; step(TCS + S + 4);
    snap(r1, d1); @(negedge clk);
    check("R7 no read no drive", d1 - d0, 0);
    snap(r0, d0); @(negedge clk);
    cs_n = 0; host_read = 1; step(2); host_read = 0; cs_n = 1; step(2); cs_n = 0; step(TCS + S + 4);
    cs_n = 1; step(S + 4);
    snap(r1, d1); @(negedge clk);
    check("R7 early end on cs fall", d1 - d0, 2);
    quad_en = 0;
    snap(r0, d0); @(negedge clk);
    cs_n = 0; host_read = 1; step(3); host_read = 0; cs_n = 1; step(TCS + S + 4);
    snap(r1, d1); @(negedge clk);
    check("R7 no drive without quad", d1 - d0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule